// File: doc/BRIEF.md
# Exact Dot-Product Long Accumulator (binary32)

This block builds dot products of single-precision floating-point vectors with no rounding at any point. On each accepted beat it takes two binary32 factors and forms their full 48-bit significand product. It aligns that product to its binary weight and adds it into a 600-bit two's-complement fixed-point register. The register spans every magnitude that such a product can have, so the register always holds the exact sum of all products accepted so far. Rounding the result back to floating point is left to whoever reads it out.

There are two independent accumulator banks, and each beat selects one of them, so two sums can grow side by side. A second stream input adds a raw 600-bit value from another unit into a chosen bank. Partial sums built on separate units can be merged this way. Each bank has a synchronous clear, a sticky flag for infinity or NaN factors, and a combinational raw readout that returns one 32-bit word at a time.

The product stream has `in_ready` tied high and accepts one beat every cycle. The merge stream and the product stream share one adder per bank. When both target the same bank in the same cycle, the product wins and `merge_ready` drops. A stalled merge source must hold `merge_valid`, `merge_bank` and `merge_data` until it sees `merge_ready` high.

Top module: `dp_long_acc`

## Requirements
- R1: After reset both bank registers read zero in every word and both `inv_flag` bits are 0.
- R2: An accepted product beat with neither exponent field equal to 255 adds (-1)^(sa XOR sb) · ma · mb · 2^(ea+eb-2) into the selected bank, modulo 2^600. Here s is bit 31, the exponent field is bits 30:23 and ma = {1, bits 22:0} for a nonzero exponent field. The register LSB weighs 2^-298.
- R3: A factor with exponent field 0 uses a hidden bit of 0 and an effective exponent of 1. A factor of ±0 leaves the bank unchanged.
- R4: A product beat in which either factor has exponent field 255 (infinity or NaN) sets `inv_flag` of the selected bank and leaves its register unchanged.
- R5: A set `inv_flag` bit stays set until that bank's `clr` bit is asserted.
- R6: `in_bank` (0 or 1) picks the bank. The other bank's register and flag do not change.
- R7: A merge beat, accepted when `merge_valid` and `merge_ready` are both high, adds `merge_data` as a 600-bit two's-complement value into bank `merge_bank`.
- R8: `in_ready` is always 1. `merge_ready` is 0 exactly when `in_valid` is high and `in_bank` equals `merge_bank`. A merge that is not accepted has no effect.
- R9: `clr[b]` zeroes bank b and its flag before any addition in the same cycle. After a clear that coincides with a product, the bank holds only that product, and its flag holds only that beat's infinity/NaN status.
- R10: `rd_data` is combinational. It shows word `rd_idx` of bank `rd_bank`, which is bits 32·idx+31 down to 32·idx of the register, with the least significant word at index 0. Word 18 carries bits 599:576 in its low 24 bits and sign-extends them. Indices 19 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Product beat valid |
| in_ready | output | 1 | Product beat ready (always 1) |
| in_bank | input | 1 | Bank for the product beat |
| in_a | input | 32 | First binary32 factor |
| in_b | input | 32 | Second binary32 factor |
| merge_valid | input | 1 | Merge beat valid |
| merge_ready | output | 1 | Merge beat ready |
| merge_bank | input | 1 | Bank for the merge beat |
| merge_data | input | 600 | Raw two's-complement value to add |
| clr | input | 2 | Per-bank synchronous clear |
| rd_bank | input | 1 | Bank for readout |
| rd_idx | input | 5 | Readout word index |
| rd_data | output | 32 | Selected 32-bit word |
| inv_flag | output | 2 | Sticky infinity/NaN flag per bank |

## Verification
Three events can land in the same cycle: a product beat, a merge beat, and a clear. The bench provokes each pairing on purpose. First, a product and a merge aimed at one bank: here `merge_ready` must be low, the merge must wait, and it must land a cycle later. Second, a product and a merge aimed at different banks: here both must land. Third, a clear together with a product: here only the new product must remain. The random phase mixes all three freely. After each cycle the bench checks `merge_ready` against the rule. It also compares every readout word of both banks with an exact big-integer model.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int ACC_W  = 600;
  localparam int NBANK  = 2;
  localparam int WORD_W = 32;
  localparam int NWORDS = (ACC_W + WORD_W - 1) / WORD_W;
  localparam int IDX_W  = $clog2(NWORDS + 1);
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int FP_W   = 32;
  localparam int MAN_W  = 24;
  localparam int EXP_W  = 8;
endpackage

// File: rtl/dp_product.sv
module dp_product #(
  parameter int ACC_W = dp_pkg::ACC_W
) (
  input  logic [31:0]      a,
  input  logic [31:0]      b,
  output logic [ACC_W-1:0] addend,
  output logic             bad
);
  localparam int PROD_W = 2 * dp_pkg::MAN_W;

  logic [7:0]        ea, eb;
  logic [8:0]        ea_eff, eb_eff, shamt;
  logic [23:0]       ma, mb;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  mag;

  always_comb begin
    ea     = a[30:23];
    eb     = b[30:23];
    ma     = {(ea != 8'd0), a[22:0]};
    mb     = {(eb != 8'd0), b[22:0]};
    ea_eff = (ea == 8'd0) ? 9'd1 : {1'b0, ea};
    eb_eff = (eb == 8'd0) ? 9'd1 : {1'b0, eb};
    shamt  = ea_eff + eb_eff - 9'd2;
    prod   = ma * mb;
    mag    = {{(ACC_W-PROD_W){1'b0}}, prod} << shamt;
    bad    = (ea == 8'hFF) || (eb == 8'hFF);
    if (bad)
      addend = '0;
    else if (a[31] ^ b[31])
      addend = -mag;
    else
      addend = mag;
  end
endmodule

// File: rtl/dp_bank.sv
module dp_bank #(
  parameter int ACC_W = dp_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             op_en,
  input  logic             op_bad,
  input  logic [ACC_W-1:0] op_val,
  output logic [ACC_W-1:0] acc,
  output logic             flag
);
  logic [ACC_W-1:0] base, term;

  always_comb begin
    base = clr ? '0 : acc;
    term = (op_en && !op_bad) ? op_val : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      flag <= 1'b0;
    end else begin
      acc  <= base + term;
      flag <= (flag && !clr) || (op_en && op_bad);
    end
  end
endmodule

// File: rtl/dp_readout.sv
module dp_readout #(
  parameter int ACC_W  = dp_pkg::ACC_W,
  parameter int NBANK  = dp_pkg::NBANK,
  parameter int WORD_W = dp_pkg::WORD_W,
  parameter int NWORDS = dp_pkg::NWORDS,
  parameter int IDX_W  = dp_pkg::IDX_W,
  parameter int BSEL_W = dp_pkg::BSEL_W
) (
  input  logic [ACC_W-1:0]  accs [NBANK],
  input  logic [BSEL_W-1:0] sel,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  localparam int PW = NWORDS * WORD_W;

  logic [ACC_W-1:0] chosen;
  logic [PW-1:0]    padded;

  always_comb begin
    chosen = accs[sel];
    padded = {PW{chosen[ACC_W-1]}};
    padded[ACC_W-1:0] = chosen;
    word = '0;
    for (int w = 0; w < NWORDS; w++)
      if (idx == IDX_W'(w))
        word = padded[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/dp_long_acc.sv
module dp_long_acc #(
  parameter int ACC_W  = dp_pkg::ACC_W,
  parameter int NBANK  = dp_pkg::NBANK,
  parameter int WORD_W = dp_pkg::WORD_W,
  parameter int NWORDS = dp_pkg::NWORDS,
  parameter int IDX_W  = dp_pkg::IDX_W,
  parameter int BSEL_W = dp_pkg::BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BSEL_W-1:0] in_bank,
  input  logic [31:0]       in_a,
  input  logic [31:0]       in_b,
  input  logic              merge_valid,
  output logic              merge_ready,
  input  logic [BSEL_W-1:0] merge_bank,
  input  logic [ACC_W-1:0]  merge_data,
  input  logic [NBANK-1:0]  clr,
  input  logic [BSEL_W-1:0] rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic [NBANK-1:0]  inv_flag
);
  logic [ACC_W-1:0] prod_addend;
  logic             prod_bad;
  logic [ACC_W-1:0] bank_acc [NBANK];

  dp_product #(.ACC_W(ACC_W)) u_prod (
    .a(in_a), .b(in_b), .addend(prod_addend), .bad(prod_bad)
  );

  assign in_ready    = 1'b1;
  assign merge_ready = !(in_valid && (in_bank == merge_bank));

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             prod_hit, mrg_hit;
    logic [ACC_W-1:0] op_val;
    assign prod_hit = in_valid && (in_bank == BSEL_W'(g));
    assign mrg_hit  = merge_valid && merge_ready && (merge_bank == BSEL_W'(g));
    assign op_val   = prod_hit ? prod_addend : merge_data;

    dp_bank #(.ACC_W(ACC_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(clr[g]),
      .op_en(prod_hit || mrg_hit), .op_bad(prod_hit && prod_bad),
      .op_val(op_val), .acc(bank_acc[g]), .flag(inv_flag[g])
    );
  end

  dp_readout #(
    .ACC_W(ACC_W), .NBANK(NBANK), .WORD_W(WORD_W),
    .NWORDS(NWORDS), .IDX_W(IDX_W), .BSEL_W(BSEL_W)
  ) u_rd (
    .accs(bank_acc), .sel(rd_bank), .idx(rd_idx), .word(rd_data)
  );
endmodule

// File: rtl/dp_long_acc_chk.sv
module dp_long_acc_chk #(
  parameter int ACC_W  = dp_pkg::ACC_W,
  parameter int NBANK  = dp_pkg::NBANK,
  parameter int BSEL_W = dp_pkg::BSEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [BSEL_W-1:0] in_bank,
  input logic [31:0]       in_a,
  input logic [31:0]       in_b,
  input logic              merge_valid,
  input logic              merge_ready,
  input logic [BSEL_W-1:0] merge_bank,
  input logic [NBANK-1:0]  clr,
  input logic [NBANK-1:0]  inv_flag,
  input logic [ACC_W-1:0]  acc0,
  input logic [ACC_W-1:0]  acc1
);
  logic bad_in, hit0, hit1, mhit0, mhit1;
  assign bad_in = (in_a[30:23] == 8'hFF) || (in_b[30:23] == 8'hFF);
  assign hit0   = in_valid && (in_bank == BSEL_W'(0));
  assign hit1   = in_valid && (in_bank == BSEL_W'(1));
  assign mhit0  = merge_valid && merge_ready && (merge_bank == BSEL_W'(0));
  assign mhit1  = merge_valid && merge_ready && (merge_bank == BSEL_W'(1));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && merge_valid && (in_bank == merge_bank)) |-> !merge_ready);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !hit0 && !mhit0) |=> (acc0 == '0) && !inv_flag[0]);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_flag[1] && !clr[1]) |=> inv_flag[1]);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && bad_in && !clr[0]) |=> (acc0 == $past(acc0)) && inv_flag[0]);

  assert_isolate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr[1] && !hit1 && !mhit1) |=> $stable(acc1));
endmodule

bind dp_long_acc dp_long_acc_chk #(.ACC_W(ACC_W), .NBANK(NBANK), .BSEL_W(BSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bank(in_bank),
  .in_a(in_a), .in_b(in_b), .merge_valid(merge_valid),
  .merge_ready(merge_ready), .merge_bank(merge_bank), .clr(clr),
  .inv_flag(inv_flag), .acc0(bank_acc[0]), .acc1(bank_acc[1])
);

// File: tb/dp_long_acc_test.sv
module dp_long_acc_test;
  localparam int AW = 600;
  localparam int NW = 19;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_bank = 0;
  logic [31:0] in_a = 0, in_b = 0;
  logic merge_valid = 0, merge_ready, merge_bank = 0;
  logic [AW-1:0] merge_data = '0;
  logic [1:0] clr = 0;
  logic rd_bank = 0;
  logic [4:0] rd_idx = 0;
  logic [31:0] rd_data;
  logic [1:0] inv_flag;

  int total = 0, bad = 0;
  bit done = 0;
  logic [AW-1:0] mdl [2];
  logic [1:0] mflag;

  always #4 clk = ~clk;

  dp_long_acc uut (.*);

  function automatic logic [AW-1:0] prod_val(logic [31:0] a, logic [31:0] b);
    logic [AW-1:0] s;
    logic [23:0] ma, mb;
    int ea, eb;
    ma = {(a[30:23] != 0), a[22:0]};
    mb = {(b[30:23] != 0), b[22:0]};
    ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
    eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
    s = '0;
    for (int i = 0; i < 24; i++)
      if (mb[i]) s = s + ({{(AW-24){1'b0}}, ma} << (i + ea + eb - 2));
    return (a[31] != b[31]) ? (~s + 1'b1) : s;
  endfunction

  function automatic bit is_bad(logic [31:0] a, logic [31:0] b);
    return (a[30:23] == 8'hFF) || (b[30:23] == 8'hFF);
  endfunction

  task automatic check(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit pv, bit pb, logic [31:0] a, logic [31:0] b,
                      bit mv, bit mb, logic [AW-1:0] md, logic [1:0] c);
    bit exp_mr, macc;
    logic [AW-1:0] base;
    @(negedge clk);
    in_valid = pv; in_bank = pb; in_a = a; in_b = b;
    merge_valid = mv; merge_bank = mb; merge_data = md; clr = c;
    #1;
    exp_mr = !(pv && pb == mb);
    check(merge_ready == exp_mr, "R8 merge_ready", AW'(merge_ready), AW'(exp_mr));
    check(in_ready == 1'b1, "R8 in_ready", AW'(in_ready), AW'(1));
    macc = mv && exp_mr;
    for (int k = 0; k < 2; k++) begin
      base = c[k] ? '0 : mdl[k];
      if (c[k]) mflag[k] = 0;
      if (pv && pb == k) begin
        if (is_bad(a, b)) mflag[k] = 1;
        else base = base + prod_val(a, b);
      end else if (macc && mb == k) base = base + md;
      mdl[k] = base;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; merge_valid = 0; clr = 0;
  endtask

  task automatic compare_bank(bit k, string tag);
    logic [NW*32-1:0] got, want;
    want = {{(NW*32-AW){mdl[k][AW-1]}}, mdl[k]};
    rd_bank = k;
    for (int w = 0; w < NW; w++) begin
      rd_idx = 5'(w); #1;
      got[w*32 +: 32] = rd_data;
    end
    check(got[AW-1:0] == want[AW-1:0] && got[NW*32-1:AW] == want[NW*32-1:AW],
          tag, got[AW-1:0], want[AW-1:0]);
    check(inv_flag[k] == mflag[k], {tag, " flag"}, AW'(inv_flag[k]), AW'(mflag[k]));
  endtask

  function automatic logic [31:0] rnd_fp();
    logic [7:0] e;
    int r = $urandom % 16;
    if (r == 0) e = 0;
    else if (r == 1) e = 8'hFF;
    else if (r == 2) e = 8'd254;
    else e = 8'(1 + $urandom % 254);
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  function automatic logic [AW-1:0] rnd_wide();
    logic [NW*32-1:0] v;
    for (int w = 0; w < NW; w++) v[w*32 +: 32] = $urandom;
    return v[AW-1:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] big;
    void'($urandom(32'd1234));
    mdl[0] = '0; mdl[1] = '0; mflag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    compare_bank(0, "R1 reset bank0");
    compare_bank(1, "R1 reset bank1");
    // R2: 1.0*1.0 sets bit 298 (word 9, bit 10)
    step(1, 0, 32'h3F800000, 32'h3F800000, 0, 0, '0, 0);
    rd_bank = 0; rd_idx = 9; #1;
    check(rd_data == 32'h400, "R2 one*one word9", AW'(rd_data), AW'(32'h400));
    // R2 negative product cancels
    step(1, 0, 32'hBF800000, 32'h3F800000, 0, 0, '0, 0);
    compare_bank(0, "R2 cancel");
    // R3 smallest subnormals -> bit 0; zero factor adds nothing
    step(1, 1, 32'h00000001, 32'h00000001, 0, 0, '0, 0);
    rd_bank = 1; rd_idx = 0; #1;
    check(rd_data == 32'h1, "R3 min subnormal", AW'(rd_data), AW'(1));
    step(1, 1, 32'h00000000, 32'h7F7FFFFF, 0, 0, '0, 0);
    compare_bank(1, "R3 zero factor");
    // R2 largest magnitude, negative
    step(1, 0, 32'hFF7FFFFF, 32'h7F7FFFFF, 0, 0, '0, 0);
    compare_bank(0, "R2 max product");
    // R4 infinity leaves register, sets flag; R6 other bank untouched
    step(1, 0, 32'h7F800000, 32'h3F800000, 0, 0, '0, 0);
    compare_bank(0, "R4 inf hold");
    compare_bank(1, "R6 other bank");
    // R5 flag sticky across normal beats
    step(1, 0, 32'h40000000, 32'h40400000, 0, 0, '0, 0);
    compare_bank(0, "R5 sticky");
    // R8 same-bank conflict: merge stalled, then accepted; R7
    big = rnd_wide();
    step(1, 1, 32'h3F800000, 32'h40000000, 1, 1, big, 0);
    compare_bank(1, "R8 stalled merge");
    step(0, 0, 0, 0, 1, 1, big, 0);
    compare_bank(1, "R7 merge");
    // different banks same cycle both land
    step(1, 0, 32'h3FC00000, 32'h3FC00000, 1, 1, rnd_wide(), 0);
    compare_bank(0, "R6 parallel prod");
    compare_bank(1, "R7 parallel merge");
    // R9 clear with same-cycle product; clear with NaN
    step(1, 0, 32'h40800000, 32'hC0000000, 0, 0, '0, 2'b01);
    compare_bank(0, "R9 clear+add");
    step(1, 1, 32'h7FC00000, 32'h3F800000, 0, 0, '0, 2'b10);
    compare_bank(1, "R9 clear+nan");
    step(0, 0, 0, 0, 0, 0, '0, 2'b11);
    compare_bank(0, "R9 clear0");
    compare_bank(1, "R9 clear1");
    // R10 out-of-range index reads zero; top word sign extension
    step(1, 0, 32'hFF7FFFFF, 32'h7F7FFFFF, 0, 0, '0, 0);
    rd_bank = 0; rd_idx = 5'd25; #1;
    check(rd_data == 32'h0, "R10 idx beyond", AW'(rd_data), '0);
    rd_idx = 5'd18; #1;
    check(rd_data == 32'hFFFFFFFF, "R10 sign ext", AW'(rd_data), AW'(32'hFFFFFFFF));
    // random mix
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 4) != 0, 1'($urandom), rnd_fp(), rnd_fp(),
           ($urandom % 3) == 0, 1'($urandom), rnd_wide(),
           (($urandom % 20) == 0) ? 2'($urandom) : 2'b00);
      if (n % 25 == 24) begin
        compare_bank(0, "R2 R7 random bank0");
        compare_bank(1, "R2 R7 random bank1");
      end
    end
    compare_bank(0, "R2 final bank0");
    compare_bank(1, "R2 final bank1");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule